// File: doc/BRIEF.md
# Coincident-Selection Bit-Cell RAM

This block is a small static RAM whose storage bits sit on a two-dimensional grid. It has no single decoder that spans the whole address space. The address is cut into a high-order row field and a low-order column field. Each field drives its own one-hot decoder. A storage bit is selected only where its row line and its column line are both high. Chip select acts on the column decoder alone. With chip select low, every column line is low and no bit can be written or read.

One column line can enable one bit or a group of adjacent bits, and this sets the data width. The default build is a 16-word by 1-bit memory on a 4x4 grid. Setting one column address bit and a two-bit word gives an 8-word by 2-bit memory on the same grid. Writes are taken on the rising clock edge. Reads are combinational from the stored bits: the selected bits are OR-ed onto the output, and an output-enable flag stands in for a tri-state driver.

Top module: `csram_array`

## Requirements
- R1: The upper ROW_BITS address bits choose the row and the lower COL_BITS bits choose the column. Bit b of the selected word is grid cell row*(2^COL_BITS*WORD_W) + col*WORD_W + b. In the 16x1 build, address 4'b1001 reaches cell 9 and no other cell.
- R2: Exactly one row line is high at all times. While chip select is high, exactly one column line is high.
- R3: While chip select is low, all column lines are low. A write strobe with chip select low changes no stored bit.
- R4: With chip select high and the write strobe low, data_out shows the selected word in the same cycle and out_en is 1.
- R5: A read, or any cycle without a write strobe, leaves every stored bit unchanged.
- R6: On a rising clock edge with chip select and write strobe both high, data_in is stored into the selected cells only. All other cells keep their values.
- R7: While chip select is low or the write strobe is high, data_out is all zeros and out_en is 0.
- R8: In the 8x2 build (ROW_BITS=2, COL_BITS=1, WORD_W=2), one column line enables two adjacent cells. data_out[0] comes from the lower-numbered cell. Address 3'b011 reaches cells 6 and 7.
- R9: After reset, every stored bit reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes take effect on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset; clears all cells |
| cs | input | 1 | Chip select; enables the column decoder |
| wr | input | 1 | 1 = write strobe, 0 = read |
| addr | input | ROW_BITS+COL_BITS | Word address; row field on top, column field below |
| data_in | input | WORD_W | Write data |
| data_out | output | WORD_W | Read data, zero while not reading |
| out_en | output | 1 | High while data_out carries a valid read |

## Verification
The bench targets the address split by writing a 1 to address 1001 alone and then reading all sixteen words. A swapped or mis-weighted row/column field would light a different cell. A write issued with chip select low must leave a previously written 1 unchanged, which separates gating of the column decoder from a decoder that ignores chip select. In the 8x2 build, the pattern 2'b10 written to address 011 shows whether the two cells of a column pair keep their bit order. Long random mixes of reads and writes, followed by full read-backs, show that no unselected cell is ever disturbed.

// File: rtl/csram_pkg.sv
package csram_pkg;

   // Cells on one grid row: every column line enables word_w adjacent cells.
   function automatic int unsigned cells_per_row(input int unsigned col_bits,
                                                 input int unsigned word_w);
      return (32'd1 << col_bits) * word_w;
   endfunction

endpackage

// File: rtl/csram_onehot_dec.sv
module csram_onehot_dec #(
   parameter int unsigned SEL_W = 2,
   localparam int unsigned LINES = 1 << SEL_W
) (
   input  logic             en,
   input  logic [SEL_W-1:0] code,
   output logic [LINES-1:0] lines
);

   if (SEL_W < 1) begin : g_bad_width
      $error("csram_onehot_dec: SEL_W must be at least 1");
   end

   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign lines[i] = en && (code == SEL_W'(i));
   end

endmodule

// File: rtl/csram_cell_grid.sv
module csram_cell_grid #(
   parameter int unsigned ROW_BITS = 2,
   parameter int unsigned COL_BITS = 2,
   parameter int unsigned WORD_W   = 1,
   localparam int unsigned ROWS    = 1 << ROW_BITS,
   localparam int unsigned COLS    = 1 << COL_BITS,
   localparam int unsigned PER_ROW = csram_pkg::cells_per_row(COL_BITS, WORD_W),
   localparam int unsigned N_CELLS = ROWS * PER_ROW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [ROWS-1:0]   row_lines,
   input  logic [COLS-1:0]   col_lines,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] rd_bits
);

   logic [N_CELLS-1:0] cells;
   logic [N_CELLS-1:0] sel_mask;

   // Coincident selection: a cell is live only where both its lines are high.
   for (genvar r = 0; r < ROWS; r++) begin : g_row
      for (genvar c = 0; c < COLS; c++) begin : g_col
         for (genvar b = 0; b < WORD_W; b++) begin : g_bit
            localparam int unsigned IDX = r * PER_ROW + c * WORD_W + b;
            assign sel_mask[IDX] = row_lines[r] & col_lines[c];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cells <= '0;
      end else if (wr) begin
         for (int i = 0; i < N_CELLS; i++) begin
            if (sel_mask[i]) cells[i] <= wdata[i % WORD_W];
         end
      end
   end

   // Wired-OR readout: every cell contributes to its bit lane when selected.
   always_comb begin
      rd_bits = '0;
      for (int i = 0; i < N_CELLS; i++) begin
         rd_bits[i % WORD_W] = rd_bits[i % WORD_W] | (cells[i] & sel_mask[i]);
      end
   end

   // R6: a write touches nothing outside the selected cells
   assert_write_local_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (((cells ^ $past(cells)) & ~$past(sel_mask)) == '0));

   // R6: the selected cells take the written data
   assert_write_takes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (sel_mask != '0)) |=> (rd_bits_of($past(sel_mask)) == $past(wdata)));

   // R5: without a write strobe the grid holds its state
   assert_read_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> (cells == $past(cells)));

   function automatic logic [WORD_W-1:0] rd_bits_of(input logic [N_CELLS-1:0] m);
      logic [WORD_W-1:0] acc;
      acc = '0;
      for (int i = 0; i < N_CELLS; i++) begin
         acc[i % WORD_W] = acc[i % WORD_W] | (cells[i] & m[i]);
      end
      return acc;
   endfunction

endmodule

// File: rtl/csram_array.sv
module csram_array #(
   parameter int unsigned ROW_BITS = 2,
   parameter int unsigned COL_BITS = 2,
   parameter int unsigned WORD_W   = 1,
   localparam int unsigned ADDR_W  = ROW_BITS + COL_BITS,
   localparam int unsigned ROWS    = 1 << ROW_BITS,
   localparam int unsigned COLS    = 1 << COL_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [WORD_W-1:0] data_in,
   output logic [WORD_W-1:0] data_out,
   output logic              out_en
);

   if (ROW_BITS < 1) begin : g_bad_rows
      $error("csram_array: ROW_BITS must be at least 1");
   end
   if (COL_BITS < 1) begin : g_bad_cols
      $error("csram_array: COL_BITS must be at least 1");
   end
   if (WORD_W < 1) begin : g_bad_word
      $error("csram_array: WORD_W must be at least 1");
   end

   logic [ROWS-1:0]   row_lines;
   logic [COLS-1:0]   col_lines;
   logic [WORD_W-1:0] rd_bits;

   // Row decoder is always on; chip select enables only the column decoder.
   csram_onehot_dec #(.SEL_W(ROW_BITS)) i_row_dec (
      .en    (1'b1),
      .code  (addr[ADDR_W-1:COL_BITS]),
      .lines (row_lines)
   );

   csram_onehot_dec #(.SEL_W(COL_BITS)) i_col_dec (
      .en    (cs),
      .code  (addr[COL_BITS-1:0]),
      .lines (col_lines)
   );

   csram_cell_grid #(
      .ROW_BITS (ROW_BITS),
      .COL_BITS (COL_BITS),
      .WORD_W   (WORD_W)
   ) i_grid (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr),
      .row_lines (row_lines),
      .col_lines (col_lines),
      .wdata     (data_in),
      .rd_bits   (rd_bits)
   );

   assign out_en   = cs & ~wr;
   assign data_out = out_en ? rd_bits : '0;

   // R2: exactly one row line is high
   assert_row_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(row_lines) == 1);

   // R2: exactly one column line while selected
   assert_col_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cs |-> ($countones(col_lines) == 1));

   // R3: column decoder is dark without chip select
   assert_col_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !cs |-> (col_lines == '0));

   // R7: output quiet unless reading
   assert_dout_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs || wr) |-> ((data_out == '0) && !out_en));

   // R4: a read raises the output enable
   assert_read_enable_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cs && !wr) |-> out_en);

endmodule

// File: tb/test_csram_array.sv
module test_csram_array;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;

   logic       a_cs = 1'b0, a_wr = 1'b0;
   logic [3:0] a_addr = '0;
   logic [0:0] a_din = '0;
   logic [0:0] a_dout;
   logic       a_en;

   logic       b_cs = 1'b0, b_wr = 1'b0;
   logic [2:0] b_addr = '0;
   logic [1:0] b_din = '0;
   logic [1:0] b_dout;
   logic       b_en;

   logic       ref_a [16];
   logic [1:0] ref_b [8];

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   csram_array i_csram_array (
      .clk(clk), .rst_n(rst_n), .cs(a_cs), .wr(a_wr), .addr(a_addr),
      .data_in(a_din), .data_out(a_dout), .out_en(a_en)
   );

   csram_array #(.ROW_BITS(2), .COL_BITS(1), .WORD_W(2)) i_csram_array_pair (
      .clk(clk), .rst_n(rst_n), .cs(b_cs), .wr(b_wr), .addr(b_addr),
      .data_in(b_din), .data_out(b_dout), .out_en(b_en)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic a_write(input logic [3:0] ad, input logic d, input string req);
      @(negedge clk);
      a_cs = 1'b1; a_wr = 1'b1; a_addr = ad; a_din = d;
      #1;
      check(a_dout == 1'b0 && a_en == 1'b0, "R7", {a_en, a_dout}, 0);
      @(posedge clk);
      ref_a[ad] = d;
      @(negedge clk);
      a_cs = 1'b0; a_wr = 1'b0;
      if (req != "") begin end
   endtask

   task automatic a_read(input logic [3:0] ad, input string req);
      @(negedge clk);
      a_cs = 1'b1; a_wr = 1'b0; a_addr = ad;
      #1;
      check(a_dout == ref_a[ad] && a_en == 1'b1, req, {a_en, a_dout}, {1'b1, ref_a[ad]});
   endtask

   task automatic b_write(input logic [2:0] ad, input logic [1:0] d);
      @(negedge clk);
      b_cs = 1'b1; b_wr = 1'b1; b_addr = ad; b_din = d;
      #1;
      check(b_dout == 2'b00 && b_en == 1'b0, "R7", {b_en, b_dout}, 0);
      @(posedge clk);
      ref_b[ad] = d;
      @(negedge clk);
      b_cs = 1'b0; b_wr = 1'b0;
   endtask

   task automatic b_read(input logic [2:0] ad, input string req);
      @(negedge clk);
      b_cs = 1'b1; b_wr = 1'b0; b_addr = ad;
      #1;
      check(b_dout == ref_b[ad] && b_en == 1'b1, req, {b_en, b_dout}, {1'b1, ref_b[ad]});
   endtask

   // R9: everything reads zero after reset
   task automatic t_reset;
      for (int i = 0; i < 16; i++) ref_a[i] = 1'b0;
      for (int i = 0; i < 8; i++)  ref_b[i] = 2'b00;
      @(negedge clk); #1;
      check(a_dout == 1'b0 && a_en == 1'b0, "R9", {a_en, a_dout}, 0);
      for (int i = 0; i < 16; i++) a_read(4'(i), "R9");
      for (int i = 0; i < 8; i++)  b_read(3'(i), "R9");
   endtask

   // R1/R6: address 1001 reaches cell 9 alone
   task automatic t_decode_1001;
      a_write(4'b1001, 1'b1, "R6");
      for (int i = 0; i < 16; i++) a_read(4'(i), "R1");
   endtask

   // R3: write strobe without chip select is ignored
   task automatic t_cs_gate;
      @(negedge clk);
      a_cs = 1'b0; a_wr = 1'b1; a_addr = 4'b1001; a_din = 1'b0;
      b_cs = 1'b0; b_wr = 1'b1; b_addr = 3'b011;  b_din = 2'b11;
      #1;
      check(a_dout == 1'b0 && a_en == 1'b0, "R7", {a_en, a_dout}, 0);
      @(posedge clk);
      @(negedge clk);
      a_wr = 1'b0; b_wr = 1'b0;
      a_read(4'b1001, "R3");
      for (int i = 0; i < 8; i++) b_read(3'(i), "R3");
   endtask

   // R5: repeated reads leave the array intact
   task automatic t_read_stable;
      for (int k = 0; k < 6; k++) a_read(4'b1001, "R5");
      for (int i = 0; i < 16; i++) a_read(4'(i), "R5");
   endtask

   // R8: pair ordering in the 8x2 build
   task automatic t_pair_011;
      b_write(3'b011, 2'b10);
      b_read(3'b011, "R8");
      check(b_dout[1] == 1'b1 && b_dout[0] == 1'b0, "R8", b_dout, 2);
      for (int i = 0; i < 8; i++) b_read(3'(i), "R8");
      b_write(3'b010, 2'b01);
      for (int i = 0; i < 8; i++) b_read(3'(i), "R8");
   endtask

   // R4/R6: random mix, then full read-back shows no stray writes
   task automatic t_random_a;
      for (int k = 0; k < 300; k++) begin
         logic [3:0] ad;
         ad = 4'($urandom_range(0, 15));
         if ($urandom_range(0, 1) == 1) a_write(ad, 1'($urandom_range(0, 1)), "R6");
         else a_read(ad, "R4");
      end
      for (int i = 0; i < 16; i++) a_read(4'(i), "R6");
   endtask

   task automatic t_random_b;
      for (int k = 0; k < 300; k++) begin
         logic [2:0] ad;
         ad = 3'($urandom_range(0, 7));
         if ($urandom_range(0, 1) == 1) b_write(ad, 2'($urandom_range(0, 3)));
         else b_read(ad, "R4");
      end
      for (int i = 0; i < 8; i++) b_read(3'(i), "R6");
   endtask

   task automatic finish_up;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset;
      t_decode_1001;
      t_cs_gate;
      t_read_stable;
      t_pair_011;
      t_random_a;
      t_random_b;
      finish_up;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      finish_up;
   end

endmodule